// File: doc/BRIEF.md
# Addressing-Mode Bus Cycle Sequencer

This block generates the exact per-clock bus traffic that an 8-bit accumulator-style processor produces while it resolves an operand's memory address. A surrounding decode stage hands it one request at a time: the addressing mode, the access kind (read, write or read-modify-write), an index choice, the operand byte already fetched from the program counter, and snapshots of the X, Y, stack pointer and program counter registers. From the next clock on, the sequencer issues one bus cycle per clock. This includes the wasted reads and writes that real silicon performs, so that memory-mapped peripherals see the same side effects.

The block does no arithmetic on data. In the final cycle of a read it passes the fetched byte to an external operation hook. In the final cycle of a write it drives onto the bus the value that the hook returns in that same cycle. A read-modify-write first writes the unmodified byte back, then writes the hook result. The block raises an interrupt-poll strobe one cycle before the last bus cycle. It raises a done pulse in the clock after the last bus cycle, and in that clock the updated program counter and stack pointer are presented.

Top module: `amseq_top`

## Requirements
- R1: After reset, and whenever no request is in flight, bus_valid_o, poll_o, done_o and hook_fire_o are low. A request is accepted while idle with start_i high. Its bus cycles begin in the following clock, one per clock. Mode codes on mode_i: 0 zero page, 1 zero page indexed, 2 absolute, 3 absolute indexed, 4 pre-indexed indirect (X), 5 post-indexed indirect (Y), 6 pull, 7 push. Kind codes on kind_i: 0 read, 1 write, 2 read-modify-write. bus_we_o is 1 for a write cycle.
- R2: Zero page uses address {0x00, operand}. Zero page indexed first reads at {0x00, operand} and discards the result. It then accesses {0x00, operand+index mod 256}. isel_i=0 selects X and isel_i=1 selects Y.
- R3: Absolute and absolute indexed modes read the high address byte at pc_i+1. The operand byte is the low byte. pc_o ends at pc_i+2 for these modes, at pc_i+1 for the other non-stack modes, and unchanged for stack modes.
- R4: In absolute indexed and post-indexed modes, the index is added to the 16-bit base. A read that leaves the high byte unchanged goes straight to the access. Any other case first reads and discards at {uncorrected high byte, indexed low byte}.
- R5: Pre-indexed indirect reads and discards at {0x00, operand}. It then reads the target low byte at {0x00, operand+X}. It then reads the high byte at {0x00, operand+X+1}. All of this address arithmetic wraps modulo 256.
- R6: Post-indexed indirect reads the pointer low byte at {0x00, operand} and the high byte at {0x00, operand+1 mod 256}. It then adds Y to the 16-bit pointer.
- R7: A read-modify-write reads the target, then writes the same unmodified byte back to the same address, then writes the hook result to that address.
- R8: In the final cycle, hook_fire_o is high. For a read, hook_operand_o equals the byte read in that cycle. For a write, the bus write data equals hook_result_i in that same cycle.
- R9: Stack cycles use address {0x01, S}. A pull reads and discards at S, then reads at S+1, and s_o ends at S+1. A push writes the hook result at S, and s_o ends at S-1. Both wrap modulo 256.
- R10: poll_o is high exactly in the cycle before the final bus cycle. For a one-cycle request it is high in the clock where start_i is accepted.
- R11: done_o pulses for one clock, in the clock right after the final bus cycle. bus_valid_o is low in that clock, and pc_o and s_o hold their final values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken while idle |
| mode_i | input | 3 | Addressing mode code |
| kind_i | input | 2 | Access kind code |
| isel_i | input | 1 | Index choice for indexed modes (0 X, 1 Y) |
| opnd_i | input | 8 | Operand byte already fetched |
| pc_i | input | 16 | Address of the operand byte |
| x_i | input | 8 | X register value |
| y_i | input | 8 | Y register value |
| s_i | input | 8 | Stack pointer value |
| bus_addr_o | output | 16 | Bus address |
| bus_valid_o | output | 1 | A bus cycle is issued this clock |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data for the current cycle |
| hook_fire_o | output | 1 | Operation hook step this clock |
| hook_operand_o | output | 8 | Byte handed to the hook |
| hook_result_i | input | 8 | Hook result, combinational |
| poll_o | output | 1 | Interrupt-poll strobe |
| done_o | output | 1 | Request complete |
| pc_o | output | 16 | Updated program counter |
| s_o | output | 8 | Updated stack pointer |

## Verification
The bench builds the block with its defaults: 8-bit data, 16-bit address, and stack page 1. The pages are therefore only 256 bytes, so random operand, index and pointer values often reach carry into the high byte, wrap within page zero, and wrap of the stack pointer. Directed requests pin down the corners: a pointer at 0xFF, a pull at S=0xFF, a push at S=0x00, and an indexed write with no carry, which must still take its extra cycle.

// File: rtl/amseq_pkg.sv
package amseq_pkg;

   typedef enum logic [2:0] {
      AM_ZP    = 3'd0,
      AM_ZPI   = 3'd1,
      AM_ABS   = 3'd2,
      AM_ABSI  = 3'd3,
      AM_PREX  = 3'd4,
      AM_POSTY = 3'd5,
      AM_PULL  = 3'd6,
      AM_PUSH  = 3'd7
   } amode_e;

   typedef enum logic [1:0] {
      AK_READ  = 2'd0,
      AK_WRITE = 2'd1,
      AK_RMW   = 2'd2,
      AK_RSVD  = 2'd3
   } akind_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BASE_DUMMY,
      ST_PTR_LO,
      ST_PTR_HI,
      ST_FETCH_HI,
      ST_CARRY_FIX,
      ST_RD,
      ST_WB,
      ST_WR,
      ST_PULL_DUMMY,
      ST_PULL_RD,
      ST_PUSH
   } seq_state_e;

   // The reserved kind code behaves as a read.
   function automatic logic kind_is_read(akind_e k);
      return (k != AK_WRITE) && (k != AK_RMW);
   endfunction

   function automatic seq_state_e access_entry(akind_e k);
      return (k == AK_WRITE) ? ST_WR : ST_RD;
   endfunction

   // Last bus cycle of a request.
   function automatic logic is_last(seq_state_e st, akind_e k);
      return (st == ST_RD && kind_is_read(k)) || st == ST_WR ||
             st == ST_PULL_RD || st == ST_PUSH;
   endfunction

endpackage

// File: rtl/amseq_core.sv
module amseq_core
   import amseq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  amode_e            mode_i,
   input  akind_e            kind_i,
   input  logic              isel_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [DATA_W-1:0] s_i,
   input  logic [DATA_W-1:0] rdata_i,
   output seq_state_e        st_o,
   output akind_e            kind_o,
   output logic [ADDR_W-1:0] eff_o,
   output logic [DATA_W-1:0] base_o,
   output logic [DATA_W-1:0] uncorr_o,
   output logic [DATA_W-1:0] hold_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] s_o,
   output logic              poll_o,
   output logic              done_o
);

   localparam int PAGE_W = ADDR_W - DATA_W;

   seq_state_e        st_q, st_d;
   amode_e            mode_q;
   akind_e            kind_q;
   logic [DATA_W-1:0] ix_q, base_q, uncorr_q, hold_q, s_q;
   logic [ADDR_W-1:0] eff_q, pc_q;
   logic              done_q;

   // Index applied at the pointer/high-byte fetch.
   logic [DATA_W-1:0] sum_lo_src;
   logic [ADDR_W-1:0] idx_sum;
   logic              carried;
   logic [DATA_W-1:0] ix_start;
   akind_e            kind_eff;

   always_comb begin
      sum_lo_src = (st_q == ST_PTR_HI) ? eff_q[DATA_W-1:0] : base_q;
      idx_sum    = ADDR_W'({rdata_i, sum_lo_src}) + ADDR_W'(ix_q);
      carried    = idx_sum[ADDR_W-1:DATA_W] != rdata_i;
   end

   always_comb begin
      if (mode_i == AM_PREX)
         ix_start = x_i;
      else if (mode_i == AM_POSTY)
         ix_start = y_i;
      else
         ix_start = isel_i ? y_i : x_i;
   end

   // Next-state selection.
   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               unique case (mode_i)
                  AM_ZP:            st_d = access_entry(kind_i);
                  AM_ZPI, AM_PREX:  st_d = ST_BASE_DUMMY;
                  AM_ABS, AM_ABSI:  st_d = ST_FETCH_HI;
                  AM_POSTY:         st_d = ST_PTR_LO;
                  AM_PULL:          st_d = ST_PULL_DUMMY;
                  default:          st_d = ST_PUSH;
               endcase
            end
         end
         ST_BASE_DUMMY: st_d = (mode_q == AM_ZPI) ? access_entry(kind_q) : ST_PTR_LO;
         ST_PTR_LO:     st_d = ST_PTR_HI;
         ST_PTR_HI: begin
            if (mode_q == AM_PREX || (kind_is_read(kind_q) && !carried))
               st_d = access_entry(kind_q);
            else
               st_d = ST_CARRY_FIX;
         end
         ST_FETCH_HI: begin
            if (mode_q == AM_ABS || (kind_is_read(kind_q) && !carried))
               st_d = access_entry(kind_q);
            else
               st_d = ST_CARRY_FIX;
         end
         ST_CARRY_FIX:  st_d = access_entry(kind_q);
         ST_RD:         st_d = (kind_q == AK_RMW) ? ST_WB : ST_IDLE;
         ST_WB:         st_d = ST_WR;
         ST_PULL_DUMMY: st_d = ST_PULL_RD;
         default:       st_d = ST_IDLE;
      endcase
   end

   // Poll strobe: the next clock carries the last bus cycle.
   always_comb begin
      kind_eff = (st_q == ST_IDLE) ? kind_i : kind_q;
      poll_o   = is_last(st_d, kind_eff) && !is_last(st_q, kind_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         mode_q   <= AM_ZP;
         kind_q   <= AK_READ;
         ix_q     <= '0;
         base_q   <= '0;
         uncorr_q <= '0;
         hold_q   <= '0;
         s_q      <= '0;
         eff_q    <= '0;
         pc_q     <= '0;
         done_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= is_last(st_q, kind_q);
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q <= mode_i;
                  kind_q <= kind_i;
                  ix_q   <= ix_start;
                  base_q <= opnd_i;
                  s_q    <= s_i;
                  eff_q  <= {{PAGE_W{1'b0}}, opnd_i};
                  pc_q   <= (mode_i == AM_PULL || mode_i == AM_PUSH) ?
                            pc_i : pc_i + ADDR_W'(1);
               end
            end
            ST_BASE_DUMMY: begin
               base_q <= base_q + ix_q;
               eff_q  <= {{PAGE_W{1'b0}}, base_q + ix_q};
            end
            ST_PTR_LO: begin
               eff_q[DATA_W-1:0] <= rdata_i;
               base_q            <= base_q + DATA_W'(1);
            end
            ST_PTR_HI: begin
               if (mode_q == AM_PREX) begin
                  eff_q[ADDR_W-1:DATA_W] <= rdata_i;
               end else begin
                  eff_q    <= idx_sum;
                  uncorr_q <= rdata_i;
               end
            end
            ST_FETCH_HI: begin
               pc_q <= pc_q + ADDR_W'(1);
               if (mode_q == AM_ABS) begin
                  eff_q <= {rdata_i, base_q};
               end else begin
                  eff_q    <= idx_sum;
                  uncorr_q <= rdata_i;
               end
            end
            ST_RD:         hold_q <= rdata_i;
            ST_PULL_DUMMY: s_q    <= s_q + DATA_W'(1);
            ST_PUSH:       s_q    <= s_q - DATA_W'(1);
            default: ;
         endcase
      end
   end

   assign st_o     = st_q;
   assign kind_o   = kind_q;
   assign eff_o    = eff_q;
   assign base_o   = base_q;
   assign uncorr_o = uncorr_q;
   assign hold_o   = hold_q;
   assign pc_o     = pc_q;
   assign s_o      = s_q;
   assign done_o   = done_q;

   // R10: the poll strobe precedes the last bus cycle, so done follows two clocks later.
   p_poll_lead_r10: assert property (@(posedge clk) disable iff (!rst_n)
      poll_o |=> ##1 done_o);

   // R11: done is only seen with the sequencer back at rest.
   p_done_rest_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (st_q == ST_IDLE));

   // R3: the high-byte fetch advances the program counter by one.
   p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_FETCH_HI) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

endmodule

// File: rtl/amseq_bus.sv
module amseq_bus
   import amseq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int STACK_PAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_e        st_i,
   input  akind_e            kind_i,
   input  logic [ADDR_W-1:0] eff_i,
   input  logic [DATA_W-1:0] base_i,
   input  logic [DATA_W-1:0] uncorr_i,
   input  logic [DATA_W-1:0] hold_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] s_i,
   input  logic [DATA_W-1:0] rdata_i,
   input  logic [DATA_W-1:0] hook_result_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              valid_o,
   output logic              we_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              hook_fire_o,
   output logic [DATA_W-1:0] hook_operand_o
);

   localparam int PAGE_W = ADDR_W - DATA_W;
   localparam logic [PAGE_W-1:0] STK_HI  = PAGE_W'(STACK_PAGE);
   localparam logic [PAGE_W-1:0] ZERO_HI = '0;

   always_comb begin
      addr_o         = '0;
      valid_o        = 1'b1;
      we_o           = 1'b0;
      wdata_o        = '0;
      hook_fire_o    = 1'b0;
      hook_operand_o = '0;
      unique case (st_i)
         ST_IDLE: valid_o = 1'b0;
         ST_BASE_DUMMY, ST_PTR_LO, ST_PTR_HI:
            addr_o = {ZERO_HI, base_i};
         ST_FETCH_HI:
            addr_o = pc_i;
         ST_CARRY_FIX:
            addr_o = {uncorr_i, eff_i[DATA_W-1:0]};
         ST_RD: begin
            addr_o = eff_i;
            if (kind_is_read(kind_i)) begin
               hook_fire_o    = 1'b1;
               hook_operand_o = rdata_i;
            end
         end
         ST_WB: begin
            addr_o  = eff_i;
            we_o    = 1'b1;
            wdata_o = hold_i;
         end
         ST_WR: begin
            addr_o         = eff_i;
            we_o           = 1'b1;
            wdata_o        = hook_result_i;
            hook_fire_o    = 1'b1;
            hook_operand_o = (kind_i == AK_RMW) ? hold_i : '0;
         end
         ST_PULL_DUMMY:
            addr_o = {STK_HI, s_i};
         ST_PULL_RD: begin
            addr_o         = {STK_HI, s_i};
            hook_fire_o    = 1'b1;
            hook_operand_o = rdata_i;
         end
         default: begin
            addr_o      = {STK_HI, s_i};
            we_o        = 1'b1;
            wdata_o     = hook_result_i;
            hook_fire_o = 1'b1;
         end
      endcase
   end

   // R7: the byte read for a modify is written back unchanged to the same address.
   p_rmw_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_RD && kind_i == AK_RMW) |=>
         (we_o && addr_o == $past(addr_o) && wdata_o == $past(rdata_i)));

   // R7: the echo write is followed by a second write to the same address.
   p_rmw_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_WB) |=> (we_o && hook_fire_o && addr_o == $past(addr_o)));

   // R4: the corrected access keeps the indexed low byte of the discarded cycle.
   p_fix_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_CARRY_FIX) |=>
         (valid_o && addr_o[DATA_W-1:0] == $past(addr_o[DATA_W-1:0])));

   // R9: a pull reads the next stack location, inside the stack page.
   p_pull_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_PULL_DUMMY) |=>
         (addr_o[DATA_W-1:0] == $past(addr_o[DATA_W-1:0]) + DATA_W'(1) &&
          addr_o[ADDR_W-1:DATA_W] == $past(addr_o[ADDR_W-1:DATA_W])));

endmodule

// File: rtl/amseq_top.sv
module amseq_top
   import amseq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 16,
   parameter int STACK_PAGE = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        mode_i,
   input  logic [1:0]        kind_i,
   input  logic              isel_i,
   input  logic [DATA_W-1:0] opnd_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [DATA_W-1:0] x_i,
   input  logic [DATA_W-1:0] y_i,
   input  logic [DATA_W-1:0] s_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_valid_o,
   output logic              bus_we_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              hook_fire_o,
   output logic [DATA_W-1:0] hook_operand_o,
   input  logic [DATA_W-1:0] hook_result_i,
   output logic              poll_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [DATA_W-1:0] s_o
);

   localparam int PAGE_W = ADDR_W - DATA_W;

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("amseq_top: address must be two data bytes wide");
      end
      if (STACK_PAGE < 0 || STACK_PAGE >= (1 << PAGE_W)) begin : g_bad_stack
         $error("amseq_top: stack page outside the high-byte range");
      end
      if (STACK_PAGE == 0) begin : g_bad_stack_zero
         $error("amseq_top: stack page must differ from page zero");
      end
   endgenerate

   seq_state_e        st;
   akind_e            kind_r;
   logic [ADDR_W-1:0] eff, pc_r;
   logic [DATA_W-1:0] base, uncorr, hold, s_r;

   amseq_core #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .mode_i   (amode_e'(mode_i)),
      .kind_i   (akind_e'(kind_i)),
      .isel_i   (isel_i),
      .opnd_i   (opnd_i),
      .pc_i     (pc_i),
      .x_i      (x_i),
      .y_i      (y_i),
      .s_i      (s_i),
      .rdata_i  (bus_rdata_i),
      .st_o     (st),
      .kind_o   (kind_r),
      .eff_o    (eff),
      .base_o   (base),
      .uncorr_o (uncorr),
      .hold_o   (hold),
      .pc_o     (pc_r),
      .s_o      (s_r),
      .poll_o   (poll_o),
      .done_o   (done_o)
   );

   amseq_bus #(
      .DATA_W     (DATA_W),
      .ADDR_W     (ADDR_W),
      .STACK_PAGE (STACK_PAGE)
   ) u_bus (
      .clk            (clk),
      .rst_n          (rst_n),
      .st_i           (st),
      .kind_i         (kind_r),
      .eff_i          (eff),
      .base_i         (base),
      .uncorr_i       (uncorr),
      .hold_i         (hold),
      .pc_i           (pc_r),
      .s_i            (s_r),
      .rdata_i        (bus_rdata_i),
      .hook_result_i  (hook_result_i),
      .addr_o         (bus_addr_o),
      .valid_o        (bus_valid_o),
      .we_o           (bus_we_o),
      .wdata_o        (bus_wdata_o),
      .hook_fire_o    (hook_fire_o),
      .hook_operand_o (hook_operand_o)
   );

   assign pc_o = pc_r;
   assign s_o  = s_r;

   // R1: no bus cycle is issued in the clock a done pulse is shown.
   p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !bus_valid_o);

endmodule

// File: tb/amseq_top_bench.sv
`timescale 1ns/1ps
module amseq_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  mode = '0;
   logic [1:0]  kind = '0;
   logic        isel = 1'b0;
   logic [7:0]  opnd = '0, xr = '0, yr = '0, sr = '0, wval = '0;
   logic [15:0] pc = '0;
   logic [15:0] addr;
   logic        valid, we, hfire, poll, done;
   logic [7:0]  wdata, rdata, hop, hres, s_out;
   logic [15:0] pc_out;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   function automatic logic [7:0] mem_f(logic [15:0] a);
      return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5A;
   endfunction

   assign rdata = mem_f(addr);
   assign hres  = hop ^ wval;

   amseq_top u_amseq_top (
      .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .kind_i(kind),
      .isel_i(isel), .opnd_i(opnd), .pc_i(pc), .x_i(xr), .y_i(yr), .s_i(sr),
      .bus_addr_o(addr), .bus_valid_o(valid), .bus_we_o(we), .bus_wdata_o(wdata),
      .bus_rdata_i(rdata), .hook_fire_o(hfire), .hook_operand_o(hop),
      .hook_result_i(hres), .poll_o(poll), .done_o(done), .pc_o(pc_out), .s_o(s_out)
   );

   task automatic check(input logic ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Expected trace for one request.
   logic [15:0] e_addr [8];
   logic        e_we   [8];
   logic [7:0]  e_wd   [8];
   string       e_tag  [8];
   int          e_n;
   logic [15:0] e_pc;
   logic [7:0]  e_s, e_hop;

   task automatic add(input logic [15:0] a, input logic w, input logic [7:0] d,
                      input string tag);
      e_addr[e_n] = a; e_we[e_n] = w; e_wd[e_n] = d; e_tag[e_n] = tag;
      e_n++;
   endtask

   task automatic carry_rule(input logic [7:0] hi, input logic [7:0] lo,
                             input logic [7:0] idx, input logic [1:0] k,
                             output logic [15:0] eff);
      logic [15:0] sum;
      sum = {hi, lo} + {8'h00, idx};
      // R4: penalty cycle unless a read without carry
      if (k != 2'd1 && k != 2'd2 && sum[15:8] == hi) begin
      end else begin
         add({hi, sum[7:0]}, 1'b0, 8'h00, "R4");
      end
      eff = sum;
   endtask

   task automatic build(input logic [2:0] m, input logic [1:0] k, input logic is,
                        input logic [7:0] op, input logic [15:0] p,
                        input logic [7:0] x, input logic [7:0] y,
                        input logic [7:0] s, input logic [7:0] wv);
      logic [7:0]  idx, lo, hi, q;
      logic [15:0] eff;
      idx = (m == 3'd4) ? x : (m == 3'd5) ? y : (is ? y : x);
      e_n = 0; e_pc = p + 16'd1; e_s = s; eff = {8'h00, op};
      case (m)
         3'd0: eff = {8'h00, op};
         3'd1: begin
            add({8'h00, op}, 1'b0, 8'h00, "R2");
            q = op + idx; eff = {8'h00, q};
         end
         3'd2: begin
            add(p + 16'd1, 1'b0, 8'h00, "R3");
            hi = mem_f(p + 16'd1); eff = {hi, op}; e_pc = p + 16'd2;
         end
         3'd3: begin
            add(p + 16'd1, 1'b0, 8'h00, "R3");
            hi = mem_f(p + 16'd1); e_pc = p + 16'd2;
            carry_rule(hi, op, idx, k, eff);
         end
         3'd4: begin
            add({8'h00, op}, 1'b0, 8'h00, "R5");
            q = op + idx;
            add({8'h00, q}, 1'b0, 8'h00, "R5"); lo = mem_f({8'h00, q});
            q = q + 8'd1;
            add({8'h00, q}, 1'b0, 8'h00, "R5"); hi = mem_f({8'h00, q});
            eff = {hi, lo};
         end
         3'd5: begin
            add({8'h00, op}, 1'b0, 8'h00, "R6"); lo = mem_f({8'h00, op});
            q = op + 8'd1;
            add({8'h00, q}, 1'b0, 8'h00, "R6"); hi = mem_f({8'h00, q});
            carry_rule(hi, lo, idx, k, eff);
         end
         3'd6: begin
            add({8'h01, s}, 1'b0, 8'h00, "R9");
            q = s + 8'd1;
            add({8'h01, q}, 1'b0, 8'h00, "R9");
            e_hop = mem_f({8'h01, q}); e_s = q; e_pc = p;
         end
         default: begin
            add({8'h01, s}, 1'b1, wv, "R9");
            e_hop = 8'h00; e_s = s - 8'd1; e_pc = p;
         end
      endcase
      if (m < 3'd6) begin
         if (k == 2'd1) begin
            add(eff, 1'b1, wv, "R8"); e_hop = 8'h00;
         end else if (k == 2'd2) begin
            add(eff, 1'b0, 8'h00, "R7");
            add(eff, 1'b1, mem_f(eff), "R7");
            add(eff, 1'b1, mem_f(eff) ^ wv, "R7");
            e_hop = mem_f(eff);
         end else begin
            add(eff, 1'b0, 8'h00, "R8"); e_hop = mem_f(eff);
         end
      end
   endtask

   task automatic run_one(input logic [2:0] m, input logic [1:0] k, input logic is,
                          input logic [7:0] op, input logic [15:0] p,
                          input logic [7:0] x, input logic [7:0] y,
                          input logic [7:0] s, input logic [7:0] wv);
      build(m, k, is, op, p, x, y, s, wv);
      @(negedge clk);
      mode = m; kind = k; isel = is; opnd = op; pc = p; xr = x; yr = y; sr = s;
      wval = wv; start = 1'b1;
      #1;
      check(poll == (e_n == 1), "R10", "poll at accept", {31'b0, poll},
            {31'b0, (e_n == 1)});
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < e_n; i++) begin
         #1;
         check(valid && addr == e_addr[i] && we == e_we[i] &&
               (!e_we[i] || wdata == e_wd[i]) && hfire == (i == e_n - 1),
               e_tag[i], $sformatf("cycle %0d mode %0d kind %0d bus", i, m, k),
               {valid, hfire, we, 5'b0, wdata, addr},
               {1'b1, (i == e_n - 1), e_we[i], 5'b0, e_we[i] ? e_wd[i] : wdata,
                e_addr[i]});
         check(poll == (i == e_n - 2), "R10", $sformatf("poll cycle %0d", i),
               {31'b0, poll}, {31'b0, (i == e_n - 2)});
         if (i == e_n - 1)
            check(hop == e_hop, "R8", "hook operand", {24'b0, hop}, {24'b0, e_hop});
         @(negedge clk);
      end
      #1;
      check(done && !valid, "R11", "done after last cycle", {30'b0, done, valid},
            {30'b0, 1'b1, 1'b0});
      check(pc_out == e_pc, "R3", "pc out", {16'b0, pc_out}, {16'b0, e_pc});
      check(s_out == e_s, "R9", "s out", {24'b0, s_out}, {24'b0, e_s});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check(!valid && !poll && !done && !hfire, "R1", "reset quiet",
            {28'b0, valid, poll, done, hfire}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      check(!valid && !done, "R1", "idle after reset", {30'b0, valid, done}, 32'h0);

      // Directed corners
      run_one(3'd0, 2'd0, 1'b0, 8'h42, 16'h1234, 8'h00, 8'h00, 8'hF0, 8'h00); // R2 zp read
      run_one(3'd1, 2'd0, 1'b0, 8'hF0, 16'h2000, 8'h20, 8'h00, 8'h00, 8'h00); // R2 wrap
      run_one(3'd1, 2'd1, 1'b1, 8'h80, 16'h2000, 8'h00, 8'h90, 8'h00, 8'h3C); // R2 Y
      run_one(3'd2, 2'd2, 1'b0, 8'h10, 16'h3000, 8'h00, 8'h00, 8'h00, 8'hA5); // R3 R7
      run_one(3'd3, 2'd0, 1'b0, 8'h10, 16'h4000, 8'h05, 8'h00, 8'h00, 8'h00); // R4 no carry
      run_one(3'd3, 2'd0, 1'b1, 8'hF0, 16'h4000, 8'h00, 8'h20, 8'h00, 8'h00); // R4 carry
      run_one(3'd3, 2'd1, 1'b0, 8'h10, 16'h4000, 8'h01, 8'h00, 8'h00, 8'h77); // R4 write
      run_one(3'd4, 2'd0, 1'b0, 8'hF0, 16'h5000, 8'h0F, 8'h00, 8'h00, 8'h00); // R5 wrap
      run_one(3'd4, 2'd2, 1'b0, 8'h20, 16'h5000, 8'h10, 8'h00, 8'h00, 8'h5F); // R5 R7
      run_one(3'd5, 2'd0, 1'b0, 8'hFF, 16'h6000, 8'h00, 8'h01, 8'h00, 8'h00); // R6 wrap
      run_one(3'd5, 2'd1, 1'b0, 8'h30, 16'h6000, 8'h00, 8'hFF, 8'h00, 8'h12); // R6 write
      run_one(3'd6, 2'd0, 1'b0, 8'h00, 16'h7000, 8'h00, 8'h00, 8'hFF, 8'h00); // R9 pull wrap
      run_one(3'd7, 2'd0, 1'b0, 8'h00, 16'h7000, 8'h00, 8'h00, 8'h00, 8'hE1); // R9 push wrap
      run_one(3'd1, 2'd2, 1'b0, 8'hFF, 16'hFFFE, 8'h01, 8'h00, 8'h00, 8'h0F); // R2 R7

      // Constrained random
      void'($urandom(32'd1234));
      for (int n = 0; n < 400; n++) begin
         run_one(3'($urandom % 8), 2'($urandom % 3), 1'($urandom % 2),
                 8'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                 8'($urandom), 8'($urandom));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule